// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer

This block writes a run of bytes into a serial NOR flash whose programming scheme streams two-byte words after a single addressed command. A caller gives a start address, a byte count and the data bytes, and the sequencer produces every command byte that a byte-level SPI shifter has to send. A leading byte at an odd address and a single trailing byte are written with one-byte program. Everything in between goes out as words: the first word frame carries the full address and later frames carry only the opcode and two data bytes. Between steps the sequencer reads the device status until the busy bit clears. It leaves word mode with write-disable, and it stops with an error when the device stays busy for too many status reads in a row.

The shifter side is a byte stream. The sequencer offers one byte at a time on `tx_valid`/`tx_ready`, marking the final byte of each chip-select frame with `tx_last`. The shifter returns exactly one received byte on `rx_valid` for every byte it accepts. The sequencer keeps one byte in flight: it offers the next byte only after the received byte for the previous one has come back. Data comes in on `in_valid`/`in_ready`. `in_ready` goes high only when a data byte is the next one to send, and the byte moves straight through to the shifter. Once a source raises `in_valid` it holds the value until `in_ready` accepts it. The shifter must keep `tx_byte`/`tx_last` in place while `tx_valid` is high without `tx_ready`. `rx_valid` is a single-cycle strobe with no back-pressure.

`start` is sampled only while `busy` is low. `done` is a one-cycle strobe. `error` and `written` are valid from that cycle and hold until the next accepted start.

Top module: `aai_word_prog`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `tx_valid` and `in_ready` are 0 and `written` is 0.
- R2: A start with a nonzero length first polls status until the device is idle, then sends write-enable as a one-byte frame 0x06. A poll is the frame 0x05, 0x00, with `tx_last` on the second byte. The byte received for the 0x00 is the status, and it reads as busy when bit 0 (`BUSY_MASK`) is set.
- R3: When the start address is odd, the next frame is 0x02, the address high, middle and low bytes, then one data byte (last). A poll follows, and the address advances by one.
- R4: While two or more bytes remain, the first word frame is 0xAD, three address bytes and two data bytes. Each later word frame is 0xAD and two data bytes. Every word frame is followed by a poll, and the address advances by two.
- R5: When fewer than two bytes remain, a one-byte frame 0x04 (write-disable) is sent and followed by a poll.
- R6: When one byte remains after that, the sequence is 0x06, then 0x02 with the three address bytes of that byte and the data byte, then a poll, then 0x04. `done` follows with no further poll.
- R7: If `POLL_LIMIT` consecutive status reads in one wait all show busy, the sequencer raises `done` with `error` = 1 and sends no further byte.
- R8: A start with length zero raises `done` in the next cycle with `error` = 0 and `written` = 0, and sends nothing.
- R9: `written` counts the data bytes handed to the shifter, never command or address bytes. On a successful `done` it equals the length.
- R10: `tx_byte` and `tx_last` hold while `tx_valid` waits for `tx_ready`. No new byte is offered until the received byte for the previous one has arrived.
- R11: `in_ready` is high only while busy and a data byte is due. Data bytes are sent in arrival order, and a successful run consumes exactly the length.
- R12: `start` is ignored while `busy` is high.
- R13: `done` lasts one cycle, with `busy` low in that cycle. `error` holds until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (sampled while idle) |
| start_addr | input | 24 | First flash byte address |
| start_len | input | LEN_W | Number of bytes to program |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| error | output | 1 | Last run aborted on poll timeout |
| written | output | LEN_W | Data bytes sent in the current or last run |
| in_valid | input | 1 | Data byte available |
| in_ready | output | 1 | Data byte taken this cycle |
| in_byte | input | 8 | Data byte |
| tx_valid | output | 1 | Byte offered to the shifter |
| tx_ready | input | 1 | Shifter accepts the byte |
| tx_byte | output | 8 | Byte to send |
| tx_last | output | 1 | Final byte of a chip-select frame |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Byte received during the matching send |

## Verification
The bench builds the block with `LEN_W` = 8 and `POLL_LIMIT` = 4. With a limit of 4, a device that answers busy three times per wait sits just under the timeout and one that never goes idle reaches it within a few frames. A stalled device can therefore be placed at the first wait or deep inside the word loop. An 8-bit length keeps runs short while still covering every combination of odd and even start address with odd and even length, including runs whose address carries into the next address byte.

// File: rtl/aai_wp_pkg.sv
package aai_wp_pkg;
  localparam int ADDR_BYTES = 3;
  localparam int ADDR_W     = 8 * ADDR_BYTES;
  localparam int BIDX_W     = $clog2(ADDR_BYTES + 3);

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_BYTE = 8'h02;
  localparam logic [7:0] OP_WORD = 8'hAD;
  localparam logic [7:0] OP_STAT = 8'h05;

  typedef enum logic [3:0] {
    PH_IDLE, PH_POLL, PH_WREN_A, PH_LEAD, PH_WORD,
    PH_WRDI_A, PH_WREN_B, PH_TRAIL, PH_WRDI_B
  } ph_t;

  typedef enum logic [2:0] {
    WT_START, WT_LEAD, WT_WORD, WT_WRDI, WT_TRAIL
  } wt_t;

  typedef enum logic [1:0] {LK_IDLE, LK_SEND, LK_WAIT} lk_t;
endpackage

// File: rtl/aai_byte_link.sv
module aai_byte_link
  import aai_wp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [7:0] req_byte,
  input  logic       req_last,
  output logic       req_idle,
  output logic       rsp_valid,
  output logic [7:0] rsp_byte,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic [7:0] tx_byte,
  output logic       tx_last,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte
);
  lk_t        st_q;
  logic [7:0] byte_q;
  logic       last_q;

  assign req_idle  = (st_q == LK_IDLE);
  assign tx_valid  = (st_q == LK_SEND);
  assign tx_byte   = byte_q;
  assign tx_last   = last_q;
  assign rsp_valid = (st_q == LK_WAIT) && rx_valid;
  assign rsp_byte  = rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LK_IDLE;
      byte_q <= '0;
      last_q <= 1'b0;
    end else begin
      unique case (st_q)
        LK_IDLE: if (req_valid) begin
          byte_q <= req_byte;
          last_q <= req_last;
          st_q   <= LK_SEND;
        end
        LK_SEND: if (tx_ready) st_q <= LK_WAIT;
        LK_WAIT: if (rx_valid) st_q <= LK_IDLE;
        default: st_q <= LK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aai_poll_guard.sv
module aai_poll_guard #(
  parameter int POLL_LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic busy_seen,
  output logic expired
);
  localparam int CW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;

  generate
    if (POLL_LIMIT <= 1) begin : g_single
      assign expired = busy_seen;
    end else begin : g_count
      logic [CW-1:0] cnt_q;
      assign expired = busy_seen && (cnt_q == CW'(POLL_LIMIT - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt_q <= '0;
        else if (clr)       cnt_q <= '0;
        else if (busy_seen) cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/aai_frame_gen.sv
module aai_frame_gen
  import aai_wp_pkg::*;
(
  input  ph_t               phase_i,
  input  logic [BIDX_W-1:0] bidx_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              first_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        byte_o,
  output logic              last_o,
  output logic              data_o
);
  localparam int DPOS = ADDR_BYTES + 1;

  logic [ADDR_W-1:0] sh;
  logic              in_addr;

  always_comb begin
    sh      = addr_i >> (8 * (ADDR_BYTES - 32'(bidx_i)));
    in_addr = (bidx_i != '0) && (32'(bidx_i) <= ADDR_BYTES);
    byte_o  = 8'h00;
    last_o  = 1'b0;
    data_o  = 1'b0;
    unique case (phase_i)
      PH_POLL: begin
        byte_o = (bidx_i == '0) ? OP_STAT : 8'h00;
        last_o = (bidx_i == BIDX_W'(1));
      end
      PH_WREN_A, PH_WREN_B: begin
        byte_o = OP_WREN;
        last_o = 1'b1;
      end
      PH_WRDI_A, PH_WRDI_B: begin
        byte_o = OP_WRDI;
        last_o = 1'b1;
      end
      PH_LEAD, PH_TRAIL: begin
        if (bidx_i == '0) byte_o = OP_BYTE;
        else if (in_addr) byte_o = sh[7:0];
        else begin
          byte_o = data_i;
          data_o = 1'b1;
          last_o = 1'b1;
        end
      end
      PH_WORD: begin
        if (bidx_i == '0) byte_o = OP_WORD;
        else if (first_i && in_addr) byte_o = sh[7:0];
        else begin
          byte_o = data_i;
          data_o = 1'b1;
          last_o = first_i ? (bidx_i == BIDX_W'(DPOS + 1)) : (bidx_i == BIDX_W'(2));
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/aai_word_prog.sv
module aai_word_prog
  import aai_wp_pkg::*;
#(
  parameter int         LEN_W      = 16,
  parameter int         POLL_LIMIT = 1024,
  parameter logic [7:0] BUSY_MASK  = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [LEN_W-1:0]  written,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_byte,
  output logic              tx_last,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte
);
  ph_t               phase_q;
  wt_t               wtag_q;
  logic [BIDX_W-1:0] bidx_q;
  logic              await_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [LEN_W-1:0]  cnt_q;
  logic              first_q;
  logic              done_q;
  logic              err_q;

  logic [7:0] fr_byte;
  logic       fr_last;
  logic       fr_data;
  logic       link_idle;
  logic       req_valid;
  logic       rsp_valid;
  logic [7:0] rsp_byte;
  logic       stat_busy;
  logic       poll_end;
  logic       guard_exp;
  ph_t        mid_ph;

  assign busy      = (phase_q != PH_IDLE);
  assign done      = done_q;
  assign error     = err_q;
  assign written   = cnt_q;
  assign req_valid = busy && !await_q && (fr_data ? in_valid : 1'b1);
  assign in_ready  = busy && !await_q && fr_data && link_idle;
  assign stat_busy = |(rsp_byte & BUSY_MASK);
  assign poll_end  = rsp_valid && (phase_q == PH_POLL) && fr_last;
  assign mid_ph    = (rem_q >= LEN_W'(2)) ? PH_WORD : PH_WRDI_A;

  aai_frame_gen u_frame (
    .phase_i (phase_q),
    .bidx_i  (bidx_q),
    .addr_i  (addr_q),
    .first_i (first_q),
    .data_i  (in_byte),
    .byte_o  (fr_byte),
    .last_o  (fr_last),
    .data_o  (fr_data)
  );

  aai_byte_link u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_byte  (fr_byte),
    .req_last  (fr_last),
    .req_idle  (link_idle),
    .rsp_valid (rsp_valid),
    .rsp_byte  (rsp_byte),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_byte   (tx_byte),
    .tx_last   (tx_last),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte)
  );

  aai_poll_guard #(.POLL_LIMIT(POLL_LIMIT)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (phase_q != PH_POLL),
    .busy_seen (poll_end && stat_busy),
    .expired   (guard_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      wtag_q  <= WT_START;
      bidx_q  <= '0;
      await_q <= 1'b0;
      addr_q  <= '0;
      rem_q   <= '0;
      cnt_q   <= '0;
      first_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (in_valid && in_ready) cnt_q <= cnt_q + 1'b1;
      if (!busy) begin
        if (start) begin
          err_q <= 1'b0;
          cnt_q <= '0;
          if (start_len == '0) begin
            done_q <= 1'b1;
          end else begin
            addr_q  <= start_addr;
            rem_q   <= start_len;
            first_q <= 1'b1;
            phase_q <= PH_POLL;
            wtag_q  <= WT_START;
            bidx_q  <= '0;
            await_q <= 1'b0;
          end
        end
      end else if (!await_q) begin
        if (req_valid && link_idle) await_q <= 1'b1;
      end else if (rsp_valid) begin
        await_q <= 1'b0;
        if (!fr_last) begin
          bidx_q <= bidx_q + 1'b1;
        end else begin
          bidx_q <= '0;
          unique case (phase_q)
            PH_POLL: begin
              if (!stat_busy) begin
                unique case (wtag_q)
                  WT_START: phase_q <= PH_WREN_A;
                  WT_LEAD, WT_WORD: phase_q <= mid_ph;
                  WT_WRDI: begin
                    if (rem_q == LEN_W'(1)) phase_q <= PH_WREN_B;
                    else begin
                      phase_q <= PH_IDLE;
                      done_q  <= 1'b1;
                    end
                  end
                  WT_TRAIL: phase_q <= PH_WRDI_B;
                  default:  phase_q <= PH_IDLE;
                endcase
              end else if (guard_exp) begin
                phase_q <= PH_IDLE;
                done_q  <= 1'b1;
                err_q   <= 1'b1;
              end
            end
            PH_WREN_A: phase_q <= addr_q[0] ? PH_LEAD : mid_ph;
            PH_LEAD, PH_TRAIL: begin
              addr_q  <= addr_q + 1'b1;
              rem_q   <= rem_q - 1'b1;
              wtag_q  <= (phase_q == PH_LEAD) ? WT_LEAD : WT_TRAIL;
              phase_q <= PH_POLL;
            end
            PH_WORD: begin
              addr_q  <= addr_q + ADDR_W'(2);
              rem_q   <= rem_q - LEN_W'(2);
              first_q <= 1'b0;
              wtag_q  <= WT_WORD;
              phase_q <= PH_POLL;
            end
            PH_WRDI_A: begin
              wtag_q  <= WT_WRDI;
              phase_q <= PH_POLL;
            end
            PH_WREN_B: phase_q <= PH_TRAIL;
            PH_WRDI_B: begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
            end
            default: phase_q <= PH_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/aai_wp_checker.sv
module aai_wp_checker #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN_W-1:0] start_len,
  input logic             busy,
  input logic             done,
  input logic             error,
  input logic [LEN_W-1:0] written,
  input logic             in_ready,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_byte,
  input logic             tx_last,
  input logic             rx_valid
);
  logic [LEN_W-1:0] len_q;
  logic             out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      out_q <= 1'b0;
    end else begin
      if (start && !busy) len_q <= start_len;
      if (tx_valid && tx_ready) out_q <= 1'b1;
      else if (rx_valid)        out_q <= 1'b0;
    end
  end

  assert_tx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte) && $stable(tx_last)));

  assert_one_in_flight_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_q |-> !tx_valid);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!tx_valid && !in_ready));

  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_err_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> done);

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (written <= len_q));

  assert_count_final_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !error) |-> (written == len_q));
endmodule

bind aai_word_prog aai_wp_checker #(.LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .start_len (start_len),
  .busy      (busy),
  .done      (done),
  .error     (error),
  .written   (written),
  .in_ready  (in_ready),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_byte   (tx_byte),
  .tx_last   (tx_last),
  .rx_valid  (rx_valid)
);

// File: tb/tb_aai_word_prog.sv
module tb_aai_word_prog;
  localparam int LW  = 8;
  localparam int LIM = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [23:0]   start_addr = '0;
  logic [LW-1:0] start_len = '0;
  logic          busy, done, error, in_ready, tx_valid, tx_last;
  logic [LW-1:0] written;
  logic          in_valid = 1'b0;
  logic [7:0]    in_byte = '0;
  logic          tx_ready = 1'b0;
  logic [7:0]    tx_byte;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_byte = '0;

  always #2 clk = ~clk;

  aai_word_prog #(.LEN_W(LW), .POLL_LIMIT(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_len(start_len), .busy(busy), .done(done), .error(error),
    .written(written), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_byte(tx_byte), .tx_last(tx_last), .rx_valid(rx_valid),
    .rx_byte(rx_byte)
  );

  int checks = 0;
  int errors = 0;

  // reference expectation
  logic [8:0]  exp_q[$];
  string       tag_q[$];
  logic [7:0]  in_q[$];
  logic [7:0]  dat[$];
  int          exp_cnt;
  bit          exp_err;
  int          wait_no;
  bit          aborted;
  int          busy_n = 0;
  int          hang_at = 0;

  // device model state
  int          dev_bidx = 0;
  logic [7:0]  dev_op = '0;
  bit          prev_poll = 1'b0;
  int          dev_wait = 0;
  int          dev_piw = 0;
  bit          rx_pend = 1'b0;
  logic [7:0]  rx_next = '0;
  logic [15:0] lf = 16'hACE1;
  bit          in_taken = 1'b0;
  bit          flush = 1'b0;
  bit          done_seen = 1'b0;
  bit          done_prev = 1'b0;
  bit          busy_at_done = 1'b0;

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic void px(bit l, logic [7:0] b, string t);
    exp_q.push_back({l, b});
    tag_q.push_back(t);
  endfunction

  function automatic void pwait(int poll_cap);
    int n;
    wait_no++;
    if (wait_no == hang_at) begin
      n = LIM;
      aborted = 1'b1;
    end else n = busy_n + 1;
    for (int i = 0; i < n; i++) begin
      px(1'b0, 8'h05, "R2");
      px(1'b1, 8'h00, "R2");
    end
    if (poll_cap < 0) aborted = aborted;
  endfunction

  function automatic void paddr(int a, string t);
    px(1'b0, 8'((a >> 16) & 255), t);
    px(1'b0, 8'((a >> 8) & 255), t);
    px(1'b0, 8'(a & 255), t);
  endfunction

  function automatic void plan(int addr, int len);
    int a, r, k;
    bit first;
    exp_q.delete(); tag_q.delete();
    wait_no = 0; aborted = 1'b0; exp_cnt = 0; exp_err = 1'b0;
    if (len == 0) return;
    a = addr; r = len; k = 0;
    pwait(0);
    if (!aborted) begin
      px(1'b1, 8'h06, "R2");
      if (a % 2 == 1) begin
        px(1'b0, 8'h02, "R3"); paddr(a, "R3");
        px(1'b1, dat[k], "R3"); k++;
        pwait(0); a++; r--;
      end
      first = 1'b1;
      while (r >= 2 && !aborted) begin
        px(1'b0, 8'hAD, "R4");
        if (first) paddr(a, "R4");
        px(1'b0, dat[k], "R4"); px(1'b1, dat[k+1], "R4"); k += 2;
        pwait(0); a += 2; r -= 2; first = 1'b0;
      end
      if (!aborted) begin
        px(1'b1, 8'h04, "R5");
        pwait(0);
      end
      if (!aborted && r == 1) begin
        px(1'b1, 8'h06, "R6");
        px(1'b0, 8'h02, "R6"); paddr(a, "R6");
        px(1'b1, dat[k], "R6"); k++;
        pwait(0);
        if (!aborted) px(1'b1, 8'h04, "R6");
      end
    end
    exp_cnt = k;
    exp_err = aborted;
  endfunction

  // shifter, device and data-source model; predictions for the next edge
  initial begin : model
    forever begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (rx_pend) begin
        rx_valid = 1'b1; rx_byte = rx_next; rx_pend = 1'b0;
      end else rx_valid = 1'b0;
      tx_ready = lf[0] | lf[3];
      if (flush) begin
        in_valid = 1'b0; in_taken = 1'b0;
      end else begin
        if (!in_valid || in_taken) begin
          in_valid = (in_q.size() > 0) && (lf[5] | lf[7]);
          if (in_valid) in_byte = in_q[0];
        end
        in_taken = 1'b0;
      end
      #1;
      if (in_valid && in_ready) begin
        void'(in_q.pop_front());
        in_taken = 1'b1;
      end
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10", "unexpected tx byte", int'(tx_byte), 0);
        end else begin
          check({tx_last, tx_byte} == exp_q[0], tag_q[0], "tx {last,byte}",
                int'({tx_last, tx_byte}), int'(exp_q[0]));
          void'(exp_q.pop_front()); void'(tag_q.pop_front());
        end
        if (dev_bidx == 0) begin
          dev_op = tx_byte;
          if (tx_byte == 8'h05 && !prev_poll) begin
            dev_wait++; dev_piw = 0;
          end
        end
        rx_next = 8'hA4;
        if (dev_op == 8'h05 && dev_bidx == 1) begin
          rx_next = {7'b1100110, (dev_wait == hang_at) || (dev_piw < busy_n)};
          dev_piw++;
        end
        rx_pend = 1'b1;
        if (tx_last) begin
          prev_poll = (dev_op == 8'h05); dev_bidx = 0;
        end else dev_bidx++;
      end
      if (done && done_prev) check(1'b0, "R13", "done longer than one cycle", 1, 0);
      if (done) begin
        done_seen = 1'b1; busy_at_done = busy;
      end
      done_prev = done;
    end
  end

  task automatic run(int addr, int len, int bn, int hang, bit inject, string req);
    int guard;
    flush = 1'b1;
    @(negedge clk); @(negedge clk);
    in_q.delete(); dat.delete();
    for (int i = 0; i < len; i++) dat.push_back(8'((addr * 7 + i * 29 + 3) & 255));
    foreach (dat[i]) in_q.push_back(dat[i]);
    busy_n = bn; hang_at = hang;
    dev_bidx = 0; prev_poll = 1'b0; dev_wait = 0; dev_piw = 0;
    plan(addr, len);
    flush = 1'b0;
    done_seen = 1'b0;
    @(negedge clk);
    start = 1'b1; start_addr = 24'(addr); start_len = LW'(len);
    @(negedge clk);
    start = 1'b0;
    if (len == 0) begin
      #2;
      check(done === 1'b1, "R8", "done one cycle after zero-length start", int'(done), 1);
    end
    if (inject) begin
      repeat (8) @(negedge clk);
      check(busy === 1'b1, "R12", "busy before stray start", int'(busy), 1);
      start = 1'b1; start_addr = 24'h00_0003; start_len = LW'(1);
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!done_seen && guard < 20000) begin
      @(negedge clk); guard++;
    end
    #2;
    check(done_seen, req, "done reached", int'(done_seen), 1);
    check(exp_q.size() == 0, req, "frames left unsent", exp_q.size(), 0);
    check(error === exp_err, "R7", "error flag", int'(error), int'(exp_err));
    check(int'(written) == exp_cnt, "R9", "written count", int'(written), exp_cnt);
    check(busy_at_done == 1'b0, "R13", "busy while done", int'(busy_at_done), 0);
    if (!exp_err) check(in_q.size() == 0, "R11", "data bytes left unconsumed", in_q.size(), 0);
    repeat (4) @(negedge clk);
    #2;
    check(error === exp_err, "R13", "error held after done", int'(error), int'(exp_err));
    check(tx_valid === 1'b0, "R7", "tx quiet after end", int'(tx_valid), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    #1;
    check(busy === 1'b0 && done === 1'b0 && error === 1'b0, "R1", "status after reset",
          int'({busy, done, error}), 0);
    check(tx_valid === 1'b0 && in_ready === 1'b0, "R1", "handshakes after reset",
          int'({tx_valid, in_ready}), 0);
    check(written === '0, "R1", "count after reset", int'(written), 0);
    rst_n = 1'b1;
    run(24'h000100, 6, 0, 0, 1'b0, "R4");
    run(24'h123457, 7, 2, 0, 1'b0, "R3");
    run(24'h00FFFF, 6, 1, 0, 1'b0, "R6");
    run(24'h000040, 5, LIM - 1, 0, 1'b0, "R2");
    run(24'h000200, 1, 0, 0, 1'b0, "R6");
    run(24'h000201, 1, 1, 0, 1'b0, "R5");
    run(24'h000301, 2, 0, 0, 1'b0, "R3");
    run(24'h000000, 0, 0, 0, 1'b0, "R8");
    run(24'h000500, 4, 0, 1, 1'b0, "R7");
    run(24'h000FFF, 9, 1, 3, 1'b0, "R7");
    run(24'h001000, 8, 0, 0, 1'b0, "R13");
    run(24'h002001, 40, 1, 0, 1'b1, "R12");
    run(24'h7FFF00, 255, 0, 0, 1'b0, "R9");
    run(24'h000010, 3, 0, 0, 1'b0, "R10");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule